// File: doc/BRIEF.md
# Partitioned Pixel-by-Coefficient Fractional Multiplier

This unit multiplies unsigned 8-bit pixel values by signed 16-bit fixed-point coefficients, several lanes at a time, and returns for each lane the middle sixteen bits of the product rounded on the first discarded bit. A 9-bit operation code picks one of seven lane arrangements. The arrangements decide which byte of the first operand and which halfword of the second operand feed each lane multiplier. In one arrangement a single coefficient is shared by all lanes. In two others, only two lanes are computed and their results are widened into 32-bit slots.

An operation is presented for one cycle with `inValid` high. Two cycles later `outValid` pulses with the 64-bit result. The unit accepts a new operation every cycle. A code outside the seven known ones still travels down the pipe, but it returns zero and raises `outIllegal`. Between results the output registers keep their last value.

Top module: `pmul8x16`

## Requirements
- R1: While `rstN` is low and on the first cycle after it rises, `outValid`, `outIllegal` and `result` are all zero.
- R2: An operation accepted with `inValid` high on a clock edge gives `outValid` high after the second following edge, for exactly one cycle per accepted operation. Operations on consecutive cycles give results on consecutive cycles, in order.
- R3: A lane forms the signed product of an unsigned 8-bit value `u` and a signed 16-bit value `c`. Its result is product bits [23:8] plus product bit 7, kept to 16 bits, so that a carry out of bit 15 wraps to zero (u=1, c=0xFFFF gives 0x0000; u=1, c=0x0080 gives 0x0001).
- R4: Code 0x031 feeds lane i (i = 0..3) with byte i of `srcA[31:0]` and halfword i of `srcB`. The result goes to `result[16i+15:16i]`, and `srcA[63:32]` has no effect.
- R5: Code 0x033 uses `srcB[31:16]` as the coefficient of every lane, and code 0x035 uses `srcB[15:0]`. Both take byte i of `srcA[31:0]` as the pixel of lane i, and both leave `srcB[63:32]` and `srcA[63:32]` without effect.
- R6: Code 0x036 takes the pixel of lane i from `srcA[16i+15:16i+8]`, and code 0x037 takes it from `srcA[16i+7:16i]`. In both, halfword i of `srcB` is the coefficient and the result goes to halfword i.
- R7: Codes 0x038 (upper byte) and 0x039 (lower byte) compute lanes 0 and 1 only, with the pixel chosen as in R6. Lane i's 16-bit result is placed at `result[32i+22:32i+7]`, every other result bit is zero, and bits [63:32] of both sources have no effect.
- R8: Any other code produces a result of zero with `outIllegal` high. The seven codes above produce `outIllegal` low.
- R9: In a cycle without a new result, `result` and `outIllegal` keep their values, whatever the inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| inValid | input | 1 | Operation strobe |
| opCode | input | 9 | Lane arrangement selector |
| srcA | input | 64 | Pixel operand |
| srcB | input | 64 | Coefficient operand |
| outValid | output | 1 | Result strobe, two cycles after `inValid` |
| outIllegal | output | 1 | Last result came from an unknown code |
| result | output | 64 | Packed lane results |

## Verification
The bench aims at the rounding edge where bits [23:8] are all ones and bit 7 is set: a design that saturates or widens there returns 0x10000 or 0xFFFF instead of zero. It mixes codes with random upper source halves, so a multiplexer that reads the wrong byte or halfword, or swaps the two broadcast halves, gives wrong lanes. For the widening codes it checks the 7-bit offset and the zero gaps, which catch an off-by-one placement or leftover lanes 2 and 3. Back-to-back issues and idle gaps with churning inputs expose a lost or repeated strobe and a result register that reloads when it should hold.

// File: rtl/pmul_pkg.sv
package pmul_pkg;

  localparam int OPC_W = 9;

  localparam logic [OPC_W-1:0] OP_MUL_LANE     = 9'h031;
  localparam logic [OPC_W-1:0] OP_MUL_ALPHA_HI = 9'h033;
  localparam logic [OPC_W-1:0] OP_MUL_ALPHA_LO = 9'h035;
  localparam logic [OPC_W-1:0] OP_MUL_BYTE_HI  = 9'h036;
  localparam logic [OPC_W-1:0] OP_MUL_BYTE_LO  = 9'h037;
  localparam logic [OPC_W-1:0] OP_WIDE_HI      = 9'h038;
  localparam logic [OPC_W-1:0] OP_WIDE_LO      = 9'h039;

  // Where the lane pixel byte comes from.
  typedef enum logic [1:0] {
    BYTE_PACKED = 2'd0,
    BYTE_HIGH   = 2'd1,
    BYTE_LOW    = 2'd2
  } byteSel_e;

  // Where the lane coefficient comes from.
  typedef enum logic [1:0] {
    COEF_LANE     = 2'd0,
    COEF_BCAST_HI = 2'd1,
    COEF_BCAST_LO = 2'd2
  } coefSel_e;

  typedef struct packed {
    logic     s1Load;
    byteSel_e byteSel;
    coefSel_e coefSel;
    logic     s2Load;
    logic     s2Widen;
    logic     s2Zero;
  } pmulStrobe_t;

endpackage

// File: rtl/pmul_lane.sv
module pmul_lane #(
  parameter int BYTE_W = 8,
  parameter int COEF_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              load,
  input  logic [BYTE_W-1:0] pix,
  input  logic [COEF_W-1:0] coef,
  output logic [COEF_W-1:0] rounded
);
  localparam int PROD_W = BYTE_W + COEF_W + 1;
  localparam int KEEP_W = COEF_W + 1;

  logic signed [PROD_W-1:0] prod;
  logic        [KEEP_W-1:0] keepNext;
  logic        [KEEP_W-1:0] keepQ;

  // Stage 1: pixel is unsigned, so widen with a zero before the signed multiply.
  always_comb begin
    prod     = $signed({1'b0, pix}) * $signed(coef);
    keepNext = KEEP_W'(prod >>> (BYTE_W - 1));
  end

  always_ff @(posedge clk) begin
    if (!rstN)      keepQ <= '0;
    else if (load)  keepQ <= keepNext;
  end

  // Stage 2 rounding: upper COEF_W kept bits plus the first dropped bit, wrapping.
  assign rounded = keepQ[KEEP_W-1:1] + {{(COEF_W-1){1'b0}}, keepQ[0]};

endmodule

// File: rtl/pmul_ctrl.sv
module pmul_ctrl
  import pmul_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic [OPC_W-1:0] opCode,
  output pmulStrobe_t      strobe,
  output logic             outValid,
  output logic             outIllegal
);
  logic     legal;
  logic     widen;
  byteSel_e byteSel;
  coefSel_e coefSel;

  logic v1;
  logic widen1;
  logic illegal1;

  always_comb begin
    legal   = 1'b1;
    widen   = 1'b0;
    byteSel = BYTE_PACKED;
    coefSel = COEF_LANE;
    case (opCode)
      OP_MUL_LANE:     ;
      OP_MUL_ALPHA_HI: coefSel = COEF_BCAST_HI;
      OP_MUL_ALPHA_LO: coefSel = COEF_BCAST_LO;
      OP_MUL_BYTE_HI:  byteSel = BYTE_HIGH;
      OP_MUL_BYTE_LO:  byteSel = BYTE_LOW;
      OP_WIDE_HI: begin byteSel = BYTE_HIGH; widen = 1'b1; end
      OP_WIDE_LO: begin byteSel = BYTE_LOW;  widen = 1'b1; end
      default:         legal = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      v1         <= 1'b0;
      widen1     <= 1'b0;
      illegal1   <= 1'b0;
      outValid   <= 1'b0;
      outIllegal <= 1'b0;
    end else begin
      v1       <= inValid;
      outValid <= v1;
      if (inValid) begin
        widen1   <= widen;
        illegal1 <= !legal;
      end
      if (v1) outIllegal <= illegal1;
    end
  end

  always_comb begin
    strobe.s1Load  = inValid;
    strobe.byteSel = byteSel;
    strobe.coefSel = coefSel;
    strobe.s2Load  = v1;
    strobe.s2Widen = widen1;
    strobe.s2Zero  = illegal1;
  end

  p_stage1_follows_r2: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> v1);
  p_stage2_follows_r2: assert property (@(posedge clk) disable iff (!rstN)
    v1 |=> outValid);
  p_no_spurious_r2: assert property (@(posedge clk) disable iff (!rstN)
    !v1 |=> !outValid);
  p_flag_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    !v1 |=> $stable(outIllegal));

endmodule

// File: rtl/pmul_datapath.sv
module pmul_datapath
  import pmul_pkg::*;
#(
  parameter int LANE_CNT = 4,
  parameter int BYTE_W   = 8,
  parameter int COEF_W   = 16
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  pmulStrobe_t                strobe,
  input  logic [LANE_CNT*COEF_W-1:0] srcA,
  input  logic [LANE_CNT*COEF_W-1:0] srcB,
  output logic [LANE_CNT*COEF_W-1:0] result
);
  localparam int DATA_W   = LANE_CNT * COEF_W;
  localparam int WIDE_CNT = LANE_CNT / 2;
  localparam int SLOT_W   = 2 * COEF_W;
  localparam int WIDE_OFS = BYTE_W - 1;

  function automatic logic [DATA_W-1:0] wideMask();
    logic [DATA_W-1:0] m;
    m = '0;
    for (int i = 0; i < WIDE_CNT; i++)
      m[SLOT_W*i + WIDE_OFS +: COEF_W] = '1;
    return m;
  endfunction

  localparam logic [DATA_W-1:0] WIDE_MASK = wideMask();

  logic [COEF_W-1:0] laneRes [LANE_CNT];
  logic [DATA_W-1:0] nextResult;

  for (genvar i = 0; i < LANE_CNT; i++) begin : g_lane
    logic [BYTE_W-1:0] pix;
    logic [COEF_W-1:0] coef;

    always_comb begin
      case (strobe.byteSel)
        BYTE_HIGH: pix = srcA[COEF_W*i + BYTE_W +: BYTE_W];
        BYTE_LOW:  pix = srcA[COEF_W*i +: BYTE_W];
        default:   pix = srcA[BYTE_W*i +: BYTE_W];
      endcase
      case (strobe.coefSel)
        COEF_BCAST_HI: coef = srcB[COEF_W +: COEF_W];
        COEF_BCAST_LO: coef = srcB[0 +: COEF_W];
        default:       coef = srcB[COEF_W*i +: COEF_W];
      endcase
    end

    pmul_lane #(.BYTE_W(BYTE_W), .COEF_W(COEF_W)) u_lane (
      .clk     (clk),
      .rstN    (rstN),
      .load    (strobe.s1Load),
      .pix     (pix),
      .coef    (coef),
      .rounded (laneRes[i])
    );
  end

  always_comb begin
    nextResult = '0;
    if (strobe.s2Zero) begin
      nextResult = '0;
    end else if (strobe.s2Widen) begin
      for (int i = 0; i < WIDE_CNT; i++)
        nextResult[SLOT_W*i + WIDE_OFS +: COEF_W] = laneRes[i];
    end else begin
      for (int i = 0; i < LANE_CNT; i++)
        nextResult[COEF_W*i +: COEF_W] = laneRes[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)              result <= '0;
    else if (strobe.s2Load) result <= nextResult;
  end

  p_illegal_zero_r8: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.s2Load && strobe.s2Zero) |=> (result == '0));
  p_widen_gaps_r7: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.s2Load && strobe.s2Widen) |=> ((result & ~WIDE_MASK) == '0));
  p_result_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.s2Load |=> $stable(result));

endmodule

// File: rtl/pmul8x16.sv
module pmul8x16
  import pmul_pkg::*;
#(
  parameter int LANE_CNT = 4,
  parameter int BYTE_W   = 8,
  parameter int COEF_W   = 16,
  localparam int DATA_W  = LANE_CNT * COEF_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [OPC_W-1:0]  opCode,
  input  logic [DATA_W-1:0] srcA,
  input  logic [DATA_W-1:0] srcB,
  output logic              outValid,
  output logic              outIllegal,
  output logic [DATA_W-1:0] result
);
  pmulStrobe_t strobe;

  pmul_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .inValid    (inValid),
    .opCode     (opCode),
    .strobe     (strobe),
    .outValid   (outValid),
    .outIllegal (outIllegal)
  );

  pmul_datapath #(
    .LANE_CNT (LANE_CNT),
    .BYTE_W   (BYTE_W),
    .COEF_W   (COEF_W)
  ) u_datapath (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .srcA   (srcA),
    .srcB   (srcB),
    .result (result)
  );

endmodule

// File: tb/pmul8x16_bench.sv
module pmul8x16_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [8:0]  opCode = '0;
  logic [63:0] srcA = '0;
  logic [63:0] srcB = '0;
  logic        outValid;
  logic        outIllegal;
  logic [63:0] result;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pmul8x16 u_pmul8x16 (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opCode(opCode),
    .srcA(srcA), .srcB(srcB), .outValid(outValid),
    .outIllegal(outIllegal), .result(result)
  );

  localparam logic [8:0] CODES [7] = '{9'h031, 9'h033, 9'h035, 9'h036,
                                       9'h037, 9'h038, 9'h039};

  function automatic bit isLegal(logic [8:0] c);
    foreach (CODES[k]) if (CODES[k] == c) return 1'b1;
    return 1'b0;
  endfunction

  // R3 lane arithmetic
  function automatic logic [15:0] laneRef(logic [7:0] u, logic [15:0] c);
    logic signed [31:0] p;
    p = $signed({24'b0, u}) * $signed({{16{c[15]}}, c});
    return p[23:8] + {15'b0, p[7]};
  endfunction

  function automatic logic [63:0] refModel(logic [8:0] c, logic [63:0] a, logic [63:0] b);
    logic [63:0] r;
    r = '0;
    case (c)
      9'h031: for (int i = 0; i < 4; i++) r[16*i +: 16] = laneRef(a[8*i +: 8], b[16*i +: 16]);
      9'h033: for (int i = 0; i < 4; i++) r[16*i +: 16] = laneRef(a[8*i +: 8], b[31:16]);
      9'h035: for (int i = 0; i < 4; i++) r[16*i +: 16] = laneRef(a[8*i +: 8], b[15:0]);
      9'h036: for (int i = 0; i < 4; i++) r[16*i +: 16] = laneRef(a[16*i+8 +: 8], b[16*i +: 16]);
      9'h037: for (int i = 0; i < 4; i++) r[16*i +: 16] = laneRef(a[16*i +: 8], b[16*i +: 16]);
      9'h038: for (int i = 0; i < 2; i++) r[32*i+7 +: 16] = laneRef(a[16*i+8 +: 8], b[16*i +: 16]);
      9'h039: for (int i = 0; i < 2; i++) r[32*i+7 +: 16] = laneRef(a[16*i +: 8], b[16*i +: 16]);
      default: r = '0;
    endcase
    return r;
  endfunction

  function automatic string reqOf(logic [8:0] c);
    case (c)
      9'h031: return "R4";
      9'h033, 9'h035: return "R5";
      9'h036, 9'h037: return "R6";
      9'h038, 9'h039: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic checkEq(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1'b1;
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // Issue one operation and check its result two cycles later.
  task automatic runOne(logic [8:0] c, logic [63:0] a, logic [63:0] b);
    @(negedge clk);
    opCode = c; srcA = a; srcB = b; inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0; srcA = {$urandom, $urandom}; srcB = {$urandom, $urandom};
    opCode = 9'($urandom);
    checkEq("R2 no early valid", {63'b0, outValid}, 64'd0);
    @(negedge clk);
    checkEq("R2 valid after two edges", {63'b0, outValid}, 64'd1);
    checkEq({reqOf(c), " result"}, result, refModel(c, a, b));
    checkEq("R8 illegal flag", {63'b0, outIllegal}, {63'b0, !isLegal(c)});
  endtask

  initial begin
    logic [63:0] held;
    logic        heldFlag;
    logic [8:0]  bc [3];
    logic [63:0] ba [3];
    logic [63:0] bb [3];
    void'($urandom(32'd1357));

    // R1 reset
    inValid = 1'b1; opCode = 9'h031; srcA = '1; srcB = '1;
    repeat (3) @(negedge clk);
    checkEq("R1 reset valid", {63'b0, outValid}, 64'd0);
    checkEq("R1 reset flag", {63'b0, outIllegal}, 64'd0);
    checkEq("R1 reset result", result, 64'd0);
    inValid = 1'b0;
    rstN = 1'b1;
    @(negedge clk);
    checkEq("R1 after reset valid", {63'b0, outValid}, 64'd0);
    checkEq("R1 after reset result", result, 64'd0);

    // R3 directed rounding corners with literal expectations
    runOne(9'h031, 64'h0000_0000_0000_0001, 64'h0000_0000_0000_FFFF);
    checkEq("R3 wrap to zero", result, 64'h0);
    runOne(9'h031, 64'h0000_0000_0000_0001, 64'h0000_0000_0000_0080);
    checkEq("R3 round up", result, 64'h1);
    runOne(9'h031, 64'hFFFF_FFFF_FFFF_FFFF, 64'h8000_8000_8000_8000);
    checkEq("R3 most negative", result, 64'h8080_8080_8080_8080);
    runOne(9'h038, 64'hFFFF_FFFF_FF00_FF00, 64'hFFFF_FFFF_7FFF_7FFF);
    checkEq("R7 widened placement", result, {32'h0, 32'h0} | (64'h7F7F << 7) | (64'h7F7F << 39));
    runOne(9'h035, 64'hDEAD_BEEF_0403_0201, 64'h1234_5678_0000_0100);
    checkEq("R5 lower alpha unity", result, 64'h0004_0003_0002_0001);
    runOne(9'h033, 64'hDEAD_BEEF_0403_0201, 64'h1234_0100_0000_0000);
    checkEq("R5 upper alpha from bits 31:16", result, 64'h0);

    // R8 illegal codes
    runOne(9'h000, {$urandom, $urandom}, {$urandom, $urandom});
    runOne(9'h032, {$urandom, $urandom}, {$urandom, $urandom});
    runOne(9'h1FF, {$urandom, $urandom}, {$urandom, $urandom});

    // R2 back-to-back issue
    for (int k = 0; k < 3; k++) begin
      bc[k] = CODES[$urandom % 7]; ba[k] = {$urandom, $urandom}; bb[k] = {$urandom, $urandom};
    end
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      if (k >= 2) begin
        checkEq("R2 back-to-back valid", {63'b0, outValid}, 64'd1);
        checkEq("R2 back-to-back order", result, refModel(bc[k-2], ba[k-2], bb[k-2]));
      end
      if (k < 3) begin
        inValid = 1'b1; opCode = bc[k]; srcA = ba[k]; srcB = bb[k];
      end else inValid = 1'b0;
    end
    @(negedge clk);
    checkEq("R2 single pulse per op", {63'b0, outValid}, 64'd0);

    // R9 hold with churning inputs, after an illegal result
    runOne(9'h0AA, {$urandom, $urandom}, {$urandom, $urandom});
    held = result; heldFlag = outIllegal;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      opCode = 9'($urandom); srcA = {$urandom, $urandom}; srcB = {$urandom, $urandom};
      checkEq("R9 result hold", result, held);
      checkEq("R9 flag hold", {63'b0, outIllegal}, {63'b0, heldFlag});
      checkEq("R9 no valid", {63'b0, outValid}, 64'd0);
    end

    // Random mix over all codes, upper source halves random (R4-R7 ignore rules)
    for (int k = 0; k < 400; k++) begin
      int pick;
      logic [8:0] c;
      pick = int'($urandom % 9);
      c = (pick < 7) ? CODES[pick] : 9'($urandom);
      runOne(c, {$urandom, $urandom}, {$urandom, $urandom});
    end

    finishRun();
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

endmodule